// File: doc/BRIEF.md
# Bit-Clear Immediate Decode and Execute Unit

This unit takes one fetched instruction word and the contents of one source register. It recognises a single operation: clear in a register every bit that is set in an immediate constant. The word may use a fixed 32-bit layout or a layout made of two 16-bit halfwords. The unit names the source register on a combinational read-index output. It expands the 12-bit immediate field into a 32-bit constant and a shifter carry, and computes `source AND NOT constant`. One clock later it presents a register-file write, a flag update, a program-counter write, an exception-return strobe or an unpredictable-encoding flag.

Condition evaluation happens outside the unit, which sees only the resulting pass bit. Every instruction that carries the valid qualifier yields exactly one output-valid pulse. Words that do not match the operation give the pulse and nothing else.

Top module: `bic_imm_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every registered output (`out_valid`, `rf_we`, `rf_waddr`, `res_data`, `flag_we`, `flags_out`, `pc_we`, `exc_ret`, `unpred`) reads zero after that edge.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. No strobe (`rf_we`, `flag_we`, `pc_we`, `exc_ret`, `unpred`) rises without `out_valid`.
- R3: With `enc_sel`=0 (fixed layout), the word matches when `instr[27:21]`=0011110 and `instr[31:28]` is not 1111. Field positions: S=`instr[20]`, Rn=`instr[19:16]`, Rd=`instr[15:12]`, imm12=`instr[11:0]`. A non-matching word raises no strobe.
- R4: With `enc_sel`=1 (halfword pair, first halfword in `instr[31:16]`), the word matches when `instr[31:27]`=11110, `instr[25:21]`=00001 and `instr[15]`=0. Field positions: S=`instr[20]`, Rn=`instr[19:16]`, Rd=`instr[11:8]`, imm12={`instr[26]`,`instr[14:12]`,`instr[7:0]`}. A non-matching word raises no strobe.
- R5: `rn_idx` equals `instr[19:16]` in the same cycle. One cycle after a valid word, `res_data` = `rn_data` AND NOT imm32 and `rf_waddr` = Rd. On a committed write to a register other than 15, `rf_we` is high.
- R6: In the fixed layout, imm32 is imm12[7:0] zero-extended and rotated right by 2×imm12[11:8]. The carry is the input C flag when that rotation is zero, and bit 31 of imm32 otherwise.
- R7: In the halfword layout with imm12[11:10]=00, imm32 repeats byte B=imm12[7:0] according to imm12[9:8]: 00 gives 000000B, 01 gives 00B00B, 10 gives B00B00, 11 gives BBBB. The carry is the input C flag. Otherwise imm32 is {1,imm12[6:0]} rotated right by imm12[11:7], and the carry is bit 31 of imm32.
- R8: On a committed register write with S=1, `flag_we` is high and `flags_out` ({N,Z,C,V} in bits 3..0) = {result[31], result==0, carry, input V}.
- R9: With S=0, `flag_we` stays low and `flags_out` equals the `flags_in` presented with the word.
- R10: With `cond_pass`=0, a matching word raises none of `rf_we`, `flag_we`, `pc_we` or `exc_ret`.
- R11: In the fixed layout with Rd=15 and the condition passing, `pc_we` is high if S=0 and `exc_ret` is high if S=1. In both cases `rf_we` and `flag_we` stay low and the target is on `res_data`. The halfword layout never raises `pc_we` or `exc_ret`.
- R12: In the halfword layout with Rd=15 or Rn=15, a matching word raises `unpred` whether or not the condition passes. In that case it raises no `rf_we`, `flag_we`, `pc_we` or `exc_ret`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the word on `instr` |
| instr | input | 32 | Instruction word |
| enc_sel | input | 1 | 0 = fixed 32-bit layout, 1 = halfword-pair layout |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| cond_pass | input | 1 | Condition test result for this word |
| rn_idx | output | 4 | Source register index (combinational) |
| rn_data | input | 32 | Source register value read at `rn_idx` |
| out_valid | output | 1 | One pulse per accepted word |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Destination register index |
| res_data | output | 32 | Result value (register or PC target) |
| flag_we | output | 1 | Flag write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| pc_we | output | 1 | Plain program-counter write |
| exc_ret | output | 1 | Exception return with `res_data` as target |
| unpred | output | 1 | Unpredictable encoding seen |

## Verification
The bench builds the unit with its defaults: 32-bit data, register 15 as the program counter, and the halfword-pair decoder generated. This configuration puts both field layouts, all four byte-replication patterns and the rotated form of the halfword expansion within reach. It also covers the per-layout handling of register 15, including exception return and unpredictable detection. The narrow-only build, with the halfword decoder removed, is not instantiated. Its effect on results is limited to words with `enc_sel`=1, which it never matches.

// File: rtl/bic_pkg.sv
package bic_pkg;

   localparam int REG_IDX_W = 4;
   localparam int IMM12_W   = 12;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   typedef struct packed {
      logic                 hit;
      logic                 wide;
      logic                 s;
      logic [REG_IDX_W-1:0] rn;
      logic [REG_IDX_W-1:0] rd;
      logic [IMM12_W-1:0]   imm12;
   } dec_t;

endpackage

// File: rtl/bic_decode.sv
module bic_decode
   import bic_pkg::*;
#(
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [31:0] instr,
   input  logic        enc_sel,
   output dec_t        dec
);

   dec_t fix_d;
   dec_t pair_d;

   // fixed layout: condition nibble on top, opcode bits below it
   always_comb begin
      fix_d.hit   = (instr[31:28] != 4'hF) && (instr[27:21] == 7'b0011110);
      fix_d.wide  = 1'b0;
      fix_d.s     = instr[20];
      fix_d.rn    = instr[19:16];
      fix_d.rd    = instr[15:12];
      fix_d.imm12 = instr[11:0];
   end

   generate
      if (WIDE_EN) begin : g_pair
         always_comb begin
            pair_d.hit   = (instr[31:27] == 5'b11110) && (instr[25:21] == 5'b00001)
                           && !instr[15];
            pair_d.wide  = 1'b1;
            pair_d.s     = instr[20];
            pair_d.rn    = instr[19:16];
            pair_d.rd    = instr[11:8];
            pair_d.imm12 = {instr[26], instr[14:12], instr[7:0]};
         end
      end else begin : g_no_pair
         always_comb pair_d = '0;
      end
   endgenerate

   assign dec = enc_sel ? pair_d : fix_d;

endmodule

// File: rtl/bic_xpand_rot.sv
module bic_xpand_rot #(
   parameter int XLEN = 32
) (
   input  logic [11:0]     imm12,
   input  logic            cin,
   output logic [XLEN-1:0] imm,
   output logic            cout
);

   localparam int ROT_W = $clog2(XLEN);

   logic [XLEN-1:0]  base;
   logic [ROT_W-1:0] amt;

   assign base = XLEN'(imm12[7:0]);
   assign amt  = ROT_W'({imm12[11:8], 1'b0});
   assign imm  = (base >> amt) | (base << (XLEN - int'(amt)));
   assign cout = (imm12[11:8] == 4'd0) ? cin : imm[XLEN-1];

endmodule

// File: rtl/bic_xpand_wide.sv
module bic_xpand_wide #(
   parameter int XLEN = 32
) (
   input  logic [11:0]     imm12,
   input  logic            cin,
   output logic [XLEN-1:0] imm,
   output logic            cout
);

   localparam int ROT_W = $clog2(XLEN);

   logic [7:0]       b;
   logic [XLEN-1:0]  seed;
   logic [ROT_W-1:0] amt;
   logic [XLEN-1:0]  rot;

   assign b    = imm12[7:0];
   assign seed = XLEN'({1'b1, imm12[6:0]});
   assign amt  = ROT_W'(imm12[11:7]);
   assign rot  = (seed >> amt) | (seed << (XLEN - int'(amt)));

   always_comb begin
      if (imm12[11:10] == 2'b00) begin
         cout = cin;
         unique case (imm12[9:8])
            2'b00:   imm = {24'h0, b};
            2'b01:   imm = {8'h0, b, 8'h0, b};
            2'b10:   imm = {b, 8'h0, b, 8'h0};
            default: imm = {b, b, b, b};
         endcase
      end else begin
         imm  = rot;
         cout = rot[XLEN-1];
      end
   end

endmodule

// File: rtl/bic_imm_unit.sv
module bic_imm_unit
   import bic_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int PC_REG  = 15,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        in_valid,
   input  logic [31:0] instr,
   input  logic        enc_sel,
   input  logic [3:0]  flags_in,
   input  logic        cond_pass,
   output logic [3:0]  rn_idx,
   input  logic [31:0] rn_data,
   output logic        out_valid,
   output logic        rf_we,
   output logic [3:0]  rf_waddr,
   output logic [31:0] res_data,
   output logic        flag_we,
   output logic [3:0]  flags_out,
   output logic        pc_we,
   output logic        exc_ret,
   output logic        unpred
);

   localparam logic [REG_IDX_W-1:0] PC_IDX = REG_IDX_W'(PC_REG);

   // elaboration-time parameter checks
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("bic_imm_unit: both encodings fix the data width at 32");
      end
      if (PC_REG < 0 || PC_REG >= (1 << REG_IDX_W)) begin : g_bad_pc
         $error("bic_imm_unit: PC_REG must be a valid register index");
      end
   endgenerate

   dec_t            dec;
   nzcv_t           fl_cur;
   nzcv_t           fl_new;
   logic [XLEN-1:0] imm_fix;
   logic [XLEN-1:0] imm_pair;
   logic [XLEN-1:0] imm_sel;
   logic            c_fix;
   logic            c_pair;
   logic            c_sel;
   logic [XLEN-1:0] result;
   logic            rd_is_pc;
   logic            rn_is_pc;
   logic            bad_enc;
   logic            commit;
   logic            nx_rf_we;
   logic            nx_pc_we;
   logic            nx_exc;
   logic            nx_flag_we;
   logic            nx_unpred;

   bic_decode #(.WIDE_EN(WIDE_EN)) u_dec (
      .instr   (instr),
      .enc_sel (enc_sel),
      .dec     (dec)
   );

   assign fl_cur = nzcv_t'(flags_in);
   assign rn_idx = dec.rn;

   bic_xpand_rot #(.XLEN(XLEN)) u_xfix (
      .imm12 (dec.imm12),
      .cin   (fl_cur.c),
      .imm   (imm_fix),
      .cout  (c_fix)
   );

   generate
      if (WIDE_EN) begin : g_xpair
         bic_xpand_wide #(.XLEN(XLEN)) u_xpair (
            .imm12 (dec.imm12),
            .cin   (fl_cur.c),
            .imm   (imm_pair),
            .cout  (c_pair)
         );
      end else begin : g_no_xpair
         assign imm_pair = '0;
         assign c_pair   = 1'b0;
      end
   endgenerate

   assign imm_sel = dec.wide ? imm_pair : imm_fix;
   assign c_sel   = dec.wide ? c_pair   : c_fix;
   assign result  = rn_data & ~imm_sel;

   assign rd_is_pc = (dec.rd == PC_IDX);
   assign rn_is_pc = (dec.rn == PC_IDX);
   assign bad_enc  = dec.wide && (rd_is_pc || rn_is_pc);
   assign commit   = in_valid && dec.hit && cond_pass;

   assign nx_rf_we   = commit && !bad_enc && !rd_is_pc;
   assign nx_pc_we   = commit && !dec.wide && rd_is_pc && !dec.s;
   assign nx_exc     = commit && !dec.wide && rd_is_pc && dec.s;
   assign nx_flag_we = nx_rf_we && dec.s;
   assign nx_unpred  = in_valid && dec.hit && bad_enc;

   always_comb begin
      if (nx_flag_we) begin
         fl_new.n = result[XLEN-1];
         fl_new.z = (result == '0);
         fl_new.c = c_sel;
         fl_new.v = fl_cur.v;
      end else begin
         fl_new = fl_cur;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         rf_we     <= 1'b0;
         rf_waddr  <= '0;
         res_data  <= '0;
         flag_we   <= 1'b0;
         flags_out <= '0;
         pc_we     <= 1'b0;
         exc_ret   <= 1'b0;
         unpred    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         rf_we     <= nx_rf_we;
         flag_we   <= nx_flag_we;
         pc_we     <= nx_pc_we;
         exc_ret   <= nx_exc;
         unpred    <= nx_unpred;
         if (in_valid) begin
            rf_waddr  <= dec.rd;
            res_data  <= result;
            flags_out <= fl_new;
         end
      end
   end

endmodule

// File: rtl/bic_imm_unit_chk.sv
module bic_imm_unit_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic        enc_sel,
   input logic        cond_pass,
   input logic [3:0]  flags_in,
   input logic        out_valid,
   input logic        rf_we,
   input logic [31:0] res_data,
   input logic        flag_we,
   input logic [3:0]  flags_out,
   input logic        pc_we,
   input logic        exc_ret,
   input logic        unpred
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid)); // R2

   AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      (rf_we || flag_we || pc_we || exc_ret || unpred) |-> out_valid); // R2

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      $countones({rf_we, pc_we, exc_ret, unpred}) <= 1); // R11

   AST_FLAGS_WITH_RF: assert property (@(posedge clk) disable iff (rst)
      flag_we |-> rf_we); // R8

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      flag_we |-> (flags_out[2] == (res_data == 32'h0))); // R8

   AST_V_KEPT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (flags_out[0] == $past(flags_in[0]))); // R8

   AST_NO_COMMIT_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cond_pass) |=> !(rf_we || flag_we || pc_we || exc_ret)); // R10

   AST_PAIR_NO_PC: assert property (@(posedge clk) disable iff (rst)
      (in_valid && enc_sel) |=> !(pc_we || exc_ret)); // R11

   AST_UNPRED_QUIET: assert property (@(posedge clk) disable iff (rst)
      unpred |-> !(rf_we || flag_we || pc_we || exc_ret)); // R12

endmodule

bind bic_imm_unit bic_imm_unit_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .enc_sel   (enc_sel),
   .cond_pass (cond_pass),
   .flags_in  (flags_in),
   .out_valid (out_valid),
   .rf_we     (rf_we),
   .res_data  (res_data),
   .flag_we   (flag_we),
   .flags_out (flags_out),
   .pc_we     (pc_we),
   .exc_ret   (exc_ret),
   .unpred    (unpred)
);

// File: tb/sim_bic_imm_unit.sv
module sim_bic_imm_unit;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] instr;
   logic        enc_sel;
   logic [3:0]  flags_in;
   logic        cond_pass;
   logic [3:0]  rn_idx;
   logic [31:0] rn_data;
   logic        out_valid;
   logic        rf_we;
   logic [3:0]  rf_waddr;
   logic [31:0] res_data;
   logic        flag_we;
   logic [3:0]  flags_out;
   logic        pc_we;
   logic        exc_ret;
   logic        unpred;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   bic_imm_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .enc_sel(enc_sel),
      .flags_in(flags_in), .cond_pass(cond_pass), .rn_idx(rn_idx), .rn_data(rn_data),
      .out_valid(out_valid), .rf_we(rf_we), .rf_waddr(rf_waddr), .res_data(res_data),
      .flag_we(flag_we), .flags_out(flags_out), .pc_we(pc_we), .exc_ret(exc_ret),
      .unpred(unpred)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // reference expansions, bit-by-bit rotation
   function automatic logic [32:0] ref_fix(logic [11:0] f, logic cin);
      logic [31:0] v = {24'h0, f[7:0]};
      for (int k = 0; k < 2 * int'(f[11:8]); k++) v = {v[0], v[31:1]};
      return {(f[11:8] == 4'd0) ? cin : v[31], v};
   endfunction

   function automatic logic [32:0] ref_pair(logic [11:0] f, logic cin);
      logic [31:0] v;
      logic [7:0]  b = f[7:0];
      if (f[11:10] == 2'b00) begin
         case (f[9:8])
            2'b00: v = {24'h0, b};
            2'b01: v = {8'h0, b, 8'h0, b};
            2'b10: v = {b, 8'h0, b, 8'h0};
            default: v = {b, b, b, b};
         endcase
         return {cin, v};
      end
      v = {24'h0, 1'b1, f[6:0]};
      for (int k = 0; k < int'(f[11:7]); k++) v = {v[0], v[31:1]};
      return {v[31], v};
   endfunction

   function automatic logic [31:0] mk_fix(logic [3:0] cnd, logic s, logic [3:0] rn,
                                          logic [3:0] rd, logic [11:0] f);
      return {cnd, 7'b0011110, s, rn, rd, f};
   endfunction

   function automatic logic [31:0] mk_pair(logic s, logic [3:0] rn, logic [3:0] rd,
                                           logic [11:0] f);
      return {5'b11110, f[11], 5'b00001, s, rn, 1'b0, f[10:8], rd, f[7:0]};
   endfunction

   task automatic apply(string tag, logic enc, logic [31:0] ins, logic [3:0] fl,
                        logic cp, logic [31:0] rv);
      logic        hit, s, bad, go;
      logic [3:0]  rn, rd, e_fl;
      logic [11:0] f;
      logic [32:0] x;
      logic [31:0] res;
      logic        e_rf, e_pc, e_exc, e_fw, e_un;
      hit = enc ? (ins[31:27] == 5'b11110 && ins[25:21] == 5'b00001 && !ins[15])
                : (ins[31:28] != 4'hF && ins[27:21] == 7'b0011110);
      s   = ins[20];
      rn  = ins[19:16];
      rd  = enc ? ins[11:8] : ins[15:12];
      f   = enc ? {ins[26], ins[14:12], ins[7:0]} : ins[11:0];
      x   = enc ? ref_pair(f, fl[1]) : ref_fix(f, fl[1]);
      res = rv & ~x[31:0];
      bad = enc && (rd == 4'd15 || rn == 4'd15);
      go  = hit && cp;
      e_rf  = go && !bad && rd != 4'd15;
      e_pc  = go && !enc && rd == 4'd15 && !s;
      e_exc = go && !enc && rd == 4'd15 && s;
      e_fw  = e_rf && s;
      e_un  = hit && bad;
      e_fl  = e_fw ? {res[31], res == 32'h0, x[32], fl[0]} : fl;

      @(negedge clk);
      in_valid = 1'b1; instr = ins; enc_sel = enc; flags_in = fl;
      cond_pass = cp; rn_data = rv;
      #1 chk(tag, "rn_idx", 32'(rn_idx), 32'(rn));
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, "out_valid", 32'(out_valid), 32'd1);
      chk(tag, "rf_we", 32'(rf_we), 32'(e_rf));
      chk(tag, "rf_waddr", 32'(rf_waddr), 32'(rd));
      chk(tag, "res_data", res_data, res);
      chk(tag, "flag_we", 32'(flag_we), 32'(e_fw));
      chk(tag, "flags_out", 32'(flags_out), 32'(e_fl));
      chk(tag, "pc_we", 32'(pc_we), 32'(e_pc));
      chk(tag, "exc_ret", 32'(exc_ret), 32'(e_exc));
      chk(tag, "unpred", 32'(unpred), 32'(e_un));
   endtask

   // R2: a cycle without in_valid leaves out_valid and all strobes low
   task automatic idle_check();
      @(negedge clk);
      chk("R2", "idle strobes", {26'h0, out_valid, rf_we, flag_we, pc_we, exc_ret, unpred}, 32'h0);
   endtask

   initial begin
      #(CLK_NS * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; instr = '0; enc_sel = 1'b0;
      flags_in = 4'h0; cond_pass = 1'b0; rn_data = '0;
      void'($urandom(32'h5EED_0B1C));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "reset outputs",
          {out_valid, rf_we, rf_waddr, flag_we, flags_out, pc_we, exc_ret, unpred}, 32'h0);
      chk("R1", "reset res_data", res_data, 32'h0);
      rst = 1'b0;
      idle_check();

      // R6: no rotation, carry passes through
      apply("R6", 1'b0, mk_fix(4'hE, 1'b1, 4'd2, 4'd3, 12'h0FF), 4'b0010, 1'b1, 32'hFFFF_FFFF);
      // R6: rotation by 8, result zero, carry from bit 31
      apply("R6", 1'b0, mk_fix(4'h0, 1'b1, 4'd4, 4'd5, 12'h4FF), 4'b0001, 1'b1, 32'hFF00_0000);
      apply("R6", 1'b0, mk_fix(4'h1, 1'b1, 4'd0, 4'd1, 12'hF81), 4'b1100, 1'b1, 32'h1234_5678);
      // R7: replication patterns and rotated form
      apply("R7", 1'b1, mk_pair(1'b1, 4'd1, 4'd2, 12'h0AB), 4'b0010, 1'b1, 32'hFFFF_FFFF);
      apply("R7", 1'b1, mk_pair(1'b1, 4'd1, 4'd2, 12'h1AB), 4'b0000, 1'b1, 32'hFFFF_FFFF);
      apply("R7", 1'b1, mk_pair(1'b1, 4'd3, 4'd4, 12'h2AB), 4'b0010, 1'b1, 32'hFFFF_FFFF);
      apply("R7", 1'b1, mk_pair(1'b1, 4'd3, 4'd4, 12'h3FF), 4'b0011, 1'b1, 32'hFFFF_FFFF);
      apply("R7", 1'b1, mk_pair(1'b1, 4'd5, 4'd6, 12'h4D5), 4'b0010, 1'b1, 32'hFFFF_FFFF);
      apply("R7", 1'b1, mk_pair(1'b1, 4'd5, 4'd6, 12'h400), 4'b0000, 1'b1, 32'h8000_0001);
      // R3: condition nibble 1111 and a broken opcode bit do not match
      apply("R3", 1'b0, mk_fix(4'hF, 1'b1, 4'd2, 4'd3, 12'h001), 4'h0, 1'b1, 32'h0000_00FF);
      apply("R3", 1'b0, mk_fix(4'hE, 1'b0, 4'd2, 4'd3, 12'h001) ^ 32'h0020_0000, 4'h0, 1'b1, 32'h7);
      // R4: halfword layout with bit 15 set does not match
      apply("R4", 1'b1, mk_pair(1'b0, 4'd2, 4'd3, 12'h001) | 32'h0000_8000, 4'h0, 1'b1, 32'h7);
      // R9: S=0 leaves flags
      apply("R9", 1'b0, mk_fix(4'hE, 1'b0, 4'd7, 4'd8, 12'h0FF), 4'b1011, 1'b1, 32'h0000_00FF);
      // R10: condition failed
      apply("R10", 1'b0, mk_fix(4'hE, 1'b1, 4'd7, 4'd8, 12'h0F0), 4'b0100, 1'b0, 32'hABCD_EF01);
      apply("R10", 1'b0, mk_fix(4'hE, 1'b1, 4'd7, 4'd15, 12'h0F0), 4'b0100, 1'b0, 32'hABCD_EF01);
      // R11: destination 15 in fixed layout
      apply("R11", 1'b0, mk_fix(4'hE, 1'b0, 4'd9, 4'd15, 12'h003), 4'b0000, 1'b1, 32'h0000_1003);
      apply("R11", 1'b0, mk_fix(4'hE, 1'b1, 4'd15, 4'd15, 12'h003), 4'b1111, 1'b1, 32'h0000_2007);
      // R12: register 15 in halfword layout
      apply("R12", 1'b1, mk_pair(1'b1, 4'd2, 4'd15, 12'h001), 4'h0, 1'b1, 32'hFF);
      apply("R12", 1'b1, mk_pair(1'b0, 4'd15, 4'd3, 12'h001), 4'h0, 1'b1, 32'hFF);
      apply("R12", 1'b1, mk_pair(1'b1, 4'd15, 4'd15, 12'h001), 4'h0, 1'b0, 32'hFF);
      idle_check();

      // R5: constrained random mix over both layouts
      for (int k = 0; k < 3000; k++) begin
         logic        enc, s, cp;
         logic [3:0]  rn, rd, cnd, fl;
         logic [11:0] f;
         logic [31:0] ins, rv;
         enc = 1'($urandom_range(0, 1));
         s   = 1'($urandom_range(0, 1));
         rn  = 4'($urandom_range(0, 15));
         rd  = 4'($urandom_range(0, 15));
         f   = 12'($urandom);
         cnd = ($urandom_range(0, 15) == 0) ? 4'hF : 4'($urandom_range(0, 14));
         ins = enc ? mk_pair(s, rn, rd, f) : mk_fix(cnd, s, rn, rd, f);
         if ($urandom_range(0, 9) == 0) ins = ins ^ (32'h1 << $urandom_range(0, 31));
         fl  = 4'($urandom);
         cp  = ($urandom_range(0, 3) != 0);
         rv  = $urandom;
         if ($urandom_range(0, 7) == 0) rv = rv & 32'h0000_00FF;
         apply("R5", enc, ins, fl, cp, rv);
         if (k % 50 == 0) idle_check();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule